// File: doc/BRIEF.md
# PHY Management Bus Master

This block lets a host processor reach the management registers of Ethernet PHY devices over the two-wire clock/data management bus. The host uses a small 32-bit register port with an address, a write strobe, write data and combinational read data. Four words are mapped at byte offsets 0x500, 0x504, 0x508 and 0x50C. The first holds the interface enable and the clock divider. The second holds the target PHY address, register address, opcode, a start bit and a ready flag. The third holds the 16-bit value to send, and the fourth returns the 16-bit value captured by the last read.

Each accepted start produces one management frame. The frame has 32 preamble ones, a start pattern, the opcode, the two addresses, a turnaround and 16 data bits. The management clock is derived from the system clock. The data line is driven through separate output, output-enable and input pins so that a pad-level tri-state can be placed outside the block. The ready flag appears in the control word and again beside the read data, so one read of the data word tells software both that the transfer has completed and what value it returned.

Top module: `mdio_host_master`

## Requirements
- R1: After reset every mapped word reads zero, the interface is disabled, `mdc` is low and `mdioOe` is low.
- R2: A write to the setup word (0x500) always stores bits 5:0 as the divider. Bit 6 sets the enable only when the divider written in that same write is nonzero. Otherwise the enable becomes 0.
- R3: Ready is 1 exactly when the interface is enabled and no frame is in progress. It reads in control bit 7 and in read-data bit 16.
- R4: While a frame runs, `mdc` has a period of 2*(divider+1) system clocks and starts low. While idle or disabled, `mdc` stays low and `mdioOe` stays low.
- R5: A write frame (opcode 01 in control bits 15:14) drives the following, MSB first, each bit changing only when `mdc` falls: 32 ones, 01, the opcode, PHY address (control bits 28:24), register address (control bits 20:16), 10, and the 16 bits of the write-data word (0x508, bits 15:0).
- R6: A read frame (opcode 10) drives the same header, then releases `mdioOe` for the two turnaround bits and the 16 data bits. It samples `mdioIn` on each rising `mdc` edge of the data bits, MSB first. It places the result in read-data bits 15:0 when the frame ends.
- R7: Ready falls on the clock edge after an accepted start (control bit 11 written as 1). It rises again 130*(divider+1) clocks after that edge, one `mdc` period after the last data bit.
- R8: A start is ignored when ready is 0 (busy or disabled) or when the opcode written with it is 00 or 11.
- R9: Reserved bits and the start bit read zero, writes to them are ignored, and unmapped addresses read zero.
- R10: Writing the setup word so that the enable becomes 0 during a frame aborts it at once. `mdc` goes low, `mdioOe` goes low, and the read-data value is kept.
- R11: Control fields written during a frame update the readable fields but do not alter the frame in progress.
- R12: A write frame leaves the read-data value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 12 | Byte address of the register access |
| regWe | input | 1 | Write strobe for one clock |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data value to drive on the management line |
| mdioOe | output | 1 | Drive enable for the management line |
| mdioIn | input | 1 | Sampled value of the management line |

## Verification
A wrong divider count shows as an `mdc` edge that is early or late by the first half period, at most divider+1 clocks after a start. A bit counter that is off by one moves the release of `mdioOe` in read frames and shifts the captured data word, so the error appears within one `mdc` period of the turnaround. It also moves the return of ready at the end of the frame. A sticky busy state or a stale enable shows up straight away at the ready bit of both words, and as `mdc` activity where none is allowed.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DIV_W    = 6;
  localparam int PHY_W    = 5;
  localparam int REG_W    = 5;
  localparam int DATA_W   = 16;
  localparam int OP_W     = 2;

  // field positions decoded by software
  localparam int EN_BIT     = 6;
  localparam int PHY_LSB    = 24;
  localparam int REG_LSB    = 16;
  localparam int OP_LSB     = 14;
  localparam int GO_BIT     = 11;
  localparam int RDY_BIT    = 7;
  localparam int RD_RDY_BIT = 16;

  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;
  localparam logic [OP_W-1:0] OP_READ  = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_TAIL  = 2'd2
  } mdioState_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic commit;
    logic clear;
  } frameCtl_t;
endpackage

// File: rtl/mdio_frame_dp.sv
module mdio_frame_dp
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameCtl_t         ctl,
  input  logic [OP_W-1:0]   opIn,
  input  logic [PHY_W-1:0]  phyIn,
  input  logic [REG_W-1:0]  regIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic [DATA_W-1:0] rdData
);
  localparam int HDR_LEN   = PRE_LEN + 2 + OP_W + PHY_W + REG_W;
  localparam int FRAME_LEN = HDR_LEN + 2 + DATA_W;

  logic [FRAME_LEN-1:0] bitsQ, oeQ, bitsD, oeD;
  logic [DATA_W-1:0]    capQ, rdQ;

  // frame image and drive mask built at load time
  always_comb begin
    if (opIn == OP_WRITE) begin
      bitsD = {{PRE_LEN{1'b1}}, 2'b01, opIn, phyIn, regIn, 2'b10, wrData};
      oeD   = '1;
    end else begin
      bitsD = {{PRE_LEN{1'b1}}, 2'b01, opIn, phyIn, regIn, {(FRAME_LEN-HDR_LEN){1'b0}}};
      oeD   = {{HDR_LEN{1'b1}}, {(FRAME_LEN-HDR_LEN){1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitsQ <= '0;
      oeQ   <= '0;
    end else if (ctl.clear) begin
      oeQ   <= '0;
    end else if (ctl.load) begin
      bitsQ <= bitsD;
      oeQ   <= oeD;
    end else if (ctl.shift) begin
      bitsQ <= {bitsQ[FRAME_LEN-2:0], 1'b0};
      oeQ   <= {oeQ[FRAME_LEN-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capQ <= '0;
      rdQ  <= '0;
    end else begin
      if (ctl.sample) capQ <= {capQ[DATA_W-2:0], mdioIn};
      if (ctl.commit) rdQ  <= capQ;
    end
  end

  assign mdioOut = bitsQ[FRAME_LEN-1];
  assign mdioOe  = oeQ[FRAME_LEN-1];
  assign rdData  = rdQ;
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_LEN   = 32,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [DATA_W-1:0] rdData,
  output frameCtl_t         ctl,
  output logic [OP_W-1:0]   ldOp,
  output logic [PHY_W-1:0]  ldPhy,
  output logic [REG_W-1:0]  ldReg,
  output logic [DATA_W-1:0] wrData,
  output logic              mdc,
  output logic              ready,
  output logic              enable,
  output logic [DIV_W-1:0]  divider
);
  localparam int FRAME_LEN  = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int DATA_START = FRAME_LEN - DATA_W;
  localparam int IDX_W      = $clog2(FRAME_LEN + 1);
  localparam logic [ADDR_W-1:0] A_SETUP = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(BASE_ADDR + 4);
  localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(BASE_ADDR + 8);
  localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(BASE_ADDR + 12);

  logic              enQ;
  logic [DIV_W-1:0]  divQ;
  logic [PHY_W-1:0]  phyQ;
  logic [REG_W-1:0]  regQ;
  logic [OP_W-1:0]   opQ;
  logic [DATA_W-1:0] wdQ;

  mdioState_e        stateQ, stateD;
  logic [DIV_W-1:0]  cntQ, cntD;
  logic [IDX_W-1:0]  idxQ, idxD;
  logic              mdcQ, mdcD;
  logic              isReadQ, isReadD;

  logic wrSetup, wrCtrl, wrData_s;
  logic newEn, opValid, startReq, edgeDue;

  assign wrSetup  = regWe && (regAddr == A_SETUP);
  assign wrCtrl   = regWe && (regAddr == A_CTRL);
  assign wrData_s = regWe && (regAddr == A_WDATA);

  assign newEn    = regWdata[EN_BIT] && (regWdata[DIV_W-1:0] != '0);
  assign ldOp     = regWdata[OP_LSB +: OP_W];
  assign ldPhy    = regWdata[PHY_LSB +: PHY_W];
  assign ldReg    = regWdata[REG_LSB +: REG_W];
  assign opValid  = (ldOp == OP_WRITE) || (ldOp == OP_READ);
  assign ready    = enQ && (stateQ == ST_IDLE);
  assign startReq = wrCtrl && regWdata[GO_BIT] && ready && opValid;
  assign edgeDue  = (cntQ == divQ);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      divQ <= '0;
      phyQ <= '0;
      regQ <= '0;
      opQ  <= '0;
      wdQ  <= '0;
    end else begin
      if (wrSetup) begin
        enQ  <= newEn;
        divQ <= regWdata[DIV_W-1:0];
      end
      if (wrCtrl) begin
        phyQ <= ldPhy;
        regQ <= ldReg;
        opQ  <= ldOp;
      end
      if (wrData_s) wdQ <= regWdata[DATA_W-1:0];
    end
  end

  // frame sequencing and clock division
  always_comb begin
    ctl     = '0;
    stateD  = stateQ;
    cntD    = cntQ;
    idxD    = idxQ;
    mdcD    = mdcQ;
    isReadD = isReadQ;
    if (wrSetup && !newEn) begin
      stateD    = ST_IDLE;
      cntD      = '0;
      mdcD      = 1'b0;
      ctl.clear = 1'b1;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (startReq) begin
            stateD   = ST_FRAME;
            cntD     = '0;
            idxD     = '0;
            mdcD     = 1'b0;
            isReadD  = (ldOp == OP_READ);
            ctl.load = 1'b1;
          end
        end
        ST_FRAME, ST_TAIL: begin
          if (edgeDue) begin
            cntD = '0;
            mdcD = !mdcQ;
            if (!mdcQ) begin
              if (stateQ == ST_FRAME && isReadQ && idxQ >= IDX_W'(DATA_START))
                ctl.sample = 1'b1;
            end else if (stateQ == ST_FRAME) begin
              ctl.shift = 1'b1;
              if (idxQ == IDX_W'(FRAME_LEN - 1)) stateD = ST_TAIL;
              else                               idxD   = idxQ + 1'b1;
            end else begin
              stateD     = ST_IDLE;
              mdcD       = 1'b0;
              ctl.commit = isReadQ;
            end
          end else begin
            cntD = cntQ + 1'b1;
          end
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      cntQ    <= '0;
      idxQ    <= '0;
      mdcQ    <= 1'b0;
      isReadQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      cntQ    <= cntD;
      idxQ    <= idxD;
      mdcQ    <= mdcD;
      isReadQ <= isReadD;
    end
  end

  // register readback
  always_comb begin
    regRdata = '0;
    if (regAddr == A_SETUP) begin
      regRdata[EN_BIT]      = enQ;
      regRdata[DIV_W-1:0]   = divQ;
    end else if (regAddr == A_CTRL) begin
      regRdata[PHY_LSB +: PHY_W] = phyQ;
      regRdata[REG_LSB +: REG_W] = regQ;
      regRdata[OP_LSB +: OP_W]   = opQ;
      regRdata[RDY_BIT]          = ready;
    end else if (regAddr == A_WDATA) begin
      regRdata[DATA_W-1:0] = wdQ;
    end else if (regAddr == A_RDATA) begin
      regRdata[DATA_W-1:0] = rdData;
      regRdata[RD_RDY_BIT] = ready;
    end
  end

  assign wrData  = wdQ;
  assign mdc     = mdcQ;
  assign enable  = enQ;
  assign divider = divQ;
endmodule

// File: rtl/mdio_host_master.sv
module mdio_host_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN   = 32,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  frameCtl_t         ctl;
  logic [OP_W-1:0]   ldOp;
  logic [PHY_W-1:0]  ldPhy;
  logic [REG_W-1:0]  ldReg;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdData;
  logic              ready;
  logic              enable;
  logic [DIV_W-1:0]  divider;

  mdio_ctrl #(
    .PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .rdData(rdData),
    .ctl(ctl), .ldOp(ldOp), .ldPhy(ldPhy), .ldReg(ldReg), .wrData(wrData),
    .mdc(mdc), .ready(ready), .enable(enable), .divider(divider)
  );

  mdio_frame_dp #(
    .PRE_LEN(PRE_LEN)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opIn(ldOp), .phyIn(ldPhy),
    .regIn(ldReg), .wrData(wrData), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdData)
  );
endmodule

// File: rtl/mdio_chk.sv
module mdio_chk
  import mdio_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h500
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic              mdc,
  input logic              mdioOe,
  input logic              ready,
  input logic              enable,
  input logic [DIV_W-1:0]  divider
);
  localparam logic [ADDR_W-1:0] A_SETUP = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(BASE_ADDR + 4);
  localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(BASE_ADDR + 12);

  logic goWrite, goOpOk;
  assign goWrite = regWe && (regAddr == A_CTRL) && regWdata[GO_BIT];
  assign goOpOk  = (regWdata[OP_LSB +: OP_W] == OP_WRITE) || (regWdata[OP_LSB +: OP_W] == OP_READ);

  // R2
  en_needs_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (divider != '0));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (!mdc && !mdioOe));

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!mdc && !mdioOe));

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goWrite && ready && goOpOk) |=> !ready);

  // R8
  bad_op_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goWrite && ready && !goOpOk) |=> ready);

  // R3
  ready_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_RDATA) |-> (regRdata[RD_RDY_BIT] == ready));

  // R9
  setup_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_SETUP) |-> (regRdata[31:EN_BIT+1] == '0));
endmodule

bind mdio_host_master mdio_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
  .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc), .mdioOe(mdioOe),
  .ready(ready), .enable(enable), .divider(divider)
);

// File: tb/test_mdio_host_master.sv
`timescale 1ns/1ps
module test_mdio_host_master;
  localparam logic [11:0] A_SET = 12'h500;
  localparam logic [11:0] A_CTL = 12'h504;
  localparam logic [11:0] A_WD  = 12'h508;
  localparam logic [11:0] A_RD  = 12'h50C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  mdio_host_master i_mdio_host_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #2.5 clk = ~clk;

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;
  bit checking = 0;
  bit done = 0;

  // reference model state
  bit          mActive = 0;
  int          mStart = 0;
  int          mH = 1;
  logic [63:0] mBits = '0;
  logic [63:0] mOe = '0;
  bit          mRead = 0;
  logic [15:0] mResp = '0;
  logic [15:0] mRdData = '0;
  logic [15:0] mWd = '0;
  bit          mEn = 0;
  logic [5:0]  mDiv = '0;
  logic [4:0]  mPhy = '0;
  logic [4:0]  mReg = '0;
  logic [1:0]  mOp = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison of the bus pins and the PHY response driver
  always @(negedge clk) begin
    if (checking) begin
      int t, p, ph;
      logic eMdc, eOe, eOut;
      t = cyc - mStart;
      if (mActive && t >= 130 * mH) begin
        mActive = 0;
        if (mRead) mRdData = mResp;
      end
      p = 0; eMdc = 0; eOe = 0; eOut = 0;
      if (mActive) begin
        p  = t / (2 * mH);
        ph = t % (2 * mH);
        eMdc = (ph >= mH);
        if (p < 64) begin
          eOe  = mOe[63 - p];
          eOut = mBits[63 - p];
        end
      end
      check(mdc == eMdc, "R4 mdc", {31'b0, mdc}, {31'b0, eMdc});
      check(mdioOe == eOe, "R5/R6 mdioOe", {31'b0, mdioOe}, {31'b0, eOe});
      if (eOe) check(mdioOut == eOut, "R5 mdioOut", {31'b0, mdioOut}, {31'b0, eOut});
      if (mActive && mRead && p >= 48 && p < 64) mdioIn = mResp[15 - (p - 48)];
      else mdioIn = 1'b1;
    end
  end

  function automatic logic [31:0] expWord(input logic [11:0] a);
    logic rdy;
    rdy = mEn && !mActive;
    case (a)
      A_SET:   return {25'b0, mEn, mDiv};
      A_CTL:   return {3'b0, mPhy, 3'b0, mReg, mOp, 6'b0, rdy, 7'b0};
      A_WD:    return {16'b0, mWd};
      A_RD:    return {15'b0, rdy, mRdData};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mkCtrl(input logic [4:0] phy, input logic [4:0] rg, input logic [1:0] op, input logic go);
    return {3'b0, phy, 3'b0, rg, op, 2'b0, go, 11'b0};
  endfunction

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    case (a)
      A_SET: begin
        mDiv = d[5:0];
        mEn  = d[6] && (d[5:0] != 6'd0);
        if (!mEn) mActive = 0;
      end
      A_CTL: begin
        if (d[11] && mEn && !mActive && (d[15:14] == 2'b01 || d[15:14] == 2'b10)) begin
          mActive = 1;
          mStart  = cyc;
          mH      = int'(mDiv) + 1;
          mRead   = (d[15:14] == 2'b10);
          mBits   = {32'hFFFF_FFFF, 2'b01, d[15:14], d[28:24], d[20:16],
                     (mRead ? 18'h0 : {2'b10, mWd})};
          mOe     = mRead ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        end
        mPhy = d[28:24];
        mReg = d[20:16];
        mOp  = d[15:14];
      end
      A_WD: mWd = d[15:0];
      default: ;
    endcase
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(posedge clk);
    #1;
    regWe = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic busRd(input logic [11:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    regAddr = a;
    #1;
    e = expWord(a);
    check(regRdata == e, tag, regRdata, e);
  endtask

  task automatic readIs(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdata == e, tag, regRdata, e);
  endtask

  // polls ready in the read-data word right after an initiating write
  task automatic pollReady(input int expCycles, input string tag);
    int k;
    k = 0;
    regAddr = A_RD;
    forever begin
      @(negedge clk);
      #1;
      if (regRdata[16]) break;
      k++;
    end
    check(k == expCycles, tag, k, expCycles);
  endtask

  task automatic waitIdle();
    while (mActive) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    checking = 1;
    // R1 reset state
    readIs(A_SET, 32'h0, "R1 setup after reset");
    readIs(A_CTL, 32'h0, "R1 control after reset");
    readIs(A_WD,  32'h0, "R1 write data after reset");
    readIs(A_RD,  32'h0, "R1 read data after reset");
    // R9 unmapped address
    readIs(12'h510, 32'h0, "R9 unmapped address");

    // R8 start while disabled
    busWr(A_CTL, mkCtrl(5'h01, 5'h02, 2'b01, 1'b1));
    repeat (6) @(negedge clk);
    busRd(A_CTL, "R8 start ignored while disabled");

    // R2 enable refused with zero divider
    busWr(A_SET, 32'h0000_0040);
    readIs(A_SET, 32'h0, "R2 enable with zero divider");
    // R9 reserved bits of setup
    busWr(A_SET, 32'hFFFF_FF81);
    readIs(A_SET, 32'h0000_0001, "R9 setup reserved bits");
    // R2 / R3 enable with divider 1
    busWr(A_SET, 32'h0000_0041);
    readIs(A_SET, 32'h0000_0041, "R2 enable accepted");
    readIs(A_RD, 32'h0001_0000, "R3 ready mirror in read word");
    // R9 / R12 write-data word
    busWr(A_WD, 32'hFFFF_A5C3);
    readIs(A_WD, 32'h0000_A5C3, "R9 write data reserved bits");
    // R8 invalid opcode with start; R9 readback of control
    busWr(A_CTL, 32'hFFFF_FFFF);
    readIs(A_CTL, 32'h1F1F_C080, "R8 R9 opcode 11 start ignored");

    // R5 R7 write frame, divider 1
    busWr(A_CTL, mkCtrl(5'h05, 5'h1A, 2'b01, 1'b1));
    pollReady(130 * 2, "R7 ready returns after write frame");
    readIs(A_RD, 32'h0001_0000, "R12 read data unchanged by write");

    // R6 read frame, divider 1
    mResp = 16'hBEEF;
    busWr(A_CTL, mkCtrl(5'h11, 5'h03, 2'b10, 1'b1));
    readIs(A_CTL, mkCtrl(5'h11, 5'h03, 2'b10, 1'b0), "R7 ready low after start");
    waitIdle();
    readIs(A_RD, 32'h0001_BEEF, "R6 read data captured");

    // R8 R11 divider 3, busy start and field change during frame
    busWr(A_SET, 32'h0000_0043);
    mResp = 16'h1234;
    busWr(A_CTL, mkCtrl(5'h0A, 5'h15, 2'b10, 1'b1));
    repeat (40) @(negedge clk);
    busWr(A_CTL, mkCtrl(5'h1E, 5'h01, 2'b01, 1'b1));
    busRd(A_CTL, "R8 start ignored while busy");
    repeat (100) @(negedge clk);
    busWr(A_CTL, mkCtrl(5'h07, 5'h09, 2'b01, 1'b0));
    readIs(A_CTL, mkCtrl(5'h07, 5'h09, 2'b01, 1'b0), "R11 fields update during frame");
    waitIdle();
    readIs(A_RD, 32'h0001_1234, "R6 R11 read data after divider 3 frame");

    // R10 abort by disabling
    mResp = 16'h5555;
    busWr(A_CTL, mkCtrl(5'h02, 5'h04, 2'b10, 1'b1));
    repeat (300) @(negedge clk);
    busWr(A_SET, 32'h0000_0003);
    repeat (20) @(negedge clk);
    readIs(A_RD, 32'h0000_1234, "R10 abort keeps read data");
    readIs(A_SET, 32'h0000_0003, "R10 disabled after abort");

    // R4 large divider write frame
    busWr(A_WD, 32'h0000_0F0F);
    busWr(A_SET, 32'h0000_007F);
    busWr(A_CTL, mkCtrl(5'h1F, 5'h00, 2'b01, 1'b1));
    pollReady(130 * 64, "R7 ready returns with divider 63");

    // R2 enable write with zero divider disables
    busWr(A_SET, 32'h0000_0040);
    readIs(A_SET, 32'h0, "R2 zero divider disables");
    readIs(A_RD, 32'h0000_1234, "R3 ready clear when disabled");
    repeat (10) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule